// File: doc/BRIEF.md
# Keyboard Matrix Column Scanner

This block walks a key matrix of eight columns and seventeen rows. It enables the output of one column line at a time and drives it low. The other column lines stay as inputs and float. The row lines are pulled high outside the block. Sixteen of them arrive on one bus, and a seventeenth arrives on a separate pin that is reported as row 16. After a programmable number of settle cycles the block samples the row lines. It compares the sample with the snapshot it holds for that column.

Each key whose level differs from the snapshot produces one event. The event carries the column index, the row index and a release flag, and it leaves on a valid/ready stream. While an event waits for the consumer, the scanner holds the active column and does nothing else. The column's snapshot is written only after its last event has been accepted. The consumer therefore sees every change exactly once, however long it stalls the stream.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: Reset state. After reset, column 0 is the only enabled column and no event is valid. Every stored snapshot is all ones, so with no key pressed no event is ever produced.
- R2: At every cycle exactly one bit of `col_oe_o` is 1. The drive level `col_drv_o` is 0 on that enabled column.
- R3: The enabled column advances 0,1,...,7 and then wraps back to 0. On each change, `col_oe_o` becomes the previous value rotated left by one bit.
- R4: When a column produces no events it stays enabled for `settle_cycles`+1 cycles. The rows are sampled in the last of those cycles, after a two-flop synchroniser, so `settle_cycles` must be at least 2 for the sample to reflect the newly enabled column.
- R5: A column whose sample equals its stored snapshot produces no event.
- R6: Each changed key produces exactly one event. `evt_col_o` (3 bits) carries the column and `evt_row_o` (5 bits) carries the row. `evt_release_o` equals the new sampled row level: 0 means the key is now pressed, 1 means it is now released.
- R7: The events of one column leave in strictly ascending row order. The separate row input is reported with row index 16, after rows 0 to 15.
- R8: While `evt_valid_o` is 1 and `evt_ready_i` is 0, the event fields stay stable, `evt_valid_o` stays 1, and the enabled column does not change.
- R9: A column's snapshot is replaced only when its last event is accepted. However long the consumer stalls, no change is lost and none is reported twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| settle_cycles | input | 8 | Cycles to wait after a column switch before sampling |
| row_main_i | input | 16 | Row lines 0 to 15, pulled high, asynchronous |
| row_extra_i | input | 1 | Separate row line, reported as row 16 |
| col_oe_o | output | 8 | Output enable per column line, one-hot |
| col_drv_o | output | 8 | Level driven on each column line; 0 on the enabled column |
| evt_valid_o | output | 1 | Event available |
| evt_ready_i | input | 1 | Consumer accepts the event |
| evt_col_o | output | 3 | Column index of the event |
| evt_row_o | output | 5 | Row index of the event (16 is the separate input) |
| evt_release_o | output | 1 | 1 = key released, 0 = key pressed |

## Verification
A column switch shows on `col_oe_o` one cycle after the edge that decides it. A row change reaches the compare two flops later, so a key change is noticed at the next sample of its column. That sample falls `settle_cycles` cycles after the switch, and its first event is valid in the following cycle. Because the exact time of a key change relative to the scan is arbitrary, the bench does not look for a single event cycle after a key change. It waits a full scan window, longer than eight columns of dwell plus their events, and then compares per-key event counts and release flags. Dwell length and column order are counted edge by edge at the falling clock, and a stall is checked on every falling edge of a thirty-cycle window.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

    typedef enum logic {
        SCAN_SETTLE = 1'b0,
        SCAN_EMIT   = 1'b1
    } scan_state_e;

endpackage

// File: rtl/kbd_row_sync.sv
module kbd_row_sync #(
    parameter int WIDTH = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // reset to the pulled-up level so no spurious change is seen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '1;
            stable_q <= '1;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/kbd_lowbit_finder.sv
module kbd_lowbit_finder #(
    parameter int WIDTH = 17,
    parameter int IDX_W = 5
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/kbd_snap_store.sv
module kbd_snap_store #(
    parameter int NUM_COLS = 8,
    parameter int NUM_ROWS = 17,
    parameter int COL_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [COL_W-1:0]    col_i,
    input  logic [NUM_ROWS-1:0] wr_data_i,
    output logic [NUM_ROWS-1:0] rd_data_o
);
    logic [NUM_ROWS-1:0] snap_q [NUM_COLS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_COLS; c++) begin
                snap_q[c] <= '1;
            end
        end else if (wr_en_i) begin
            snap_q[col_i] <= wr_data_i;
        end
    end

    assign rd_data_o = snap_q[col_i];
endmodule

// File: rtl/kbd_matrix_scanner.sv
module kbd_matrix_scanner #(
    parameter int NUM_COLS  = 8,
    parameter int MAIN_ROWS = 16,
    parameter int SETTLE_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SETTLE_W-1:0]           settle_cycles,
    input  logic [MAIN_ROWS-1:0]          row_main_i,
    input  logic                          row_extra_i,
    output logic [NUM_COLS-1:0]           col_oe_o,
    output logic [NUM_COLS-1:0]           col_drv_o,
    output logic                          evt_valid_o,
    input  logic                          evt_ready_i,
    output logic [$clog2(NUM_COLS)-1:0]   evt_col_o,
    output logic [$clog2(MAIN_ROWS+1)-1:0] evt_row_o,
    output logic                          evt_release_o
);
    import kbd_scan_pkg::*;

    localparam int NUM_ROWS = MAIN_ROWS + 1;
    localparam int COL_W    = $clog2(NUM_COLS);
    localparam int ROW_W    = $clog2(NUM_ROWS);

    typedef struct packed {
        scan_state_e         st;
        logic [COL_W-1:0]    col;
        logic [SETTLE_W-1:0] cnt;
        logic [NUM_ROWS-1:0] sample;
        logic [NUM_ROWS-1:0] pending;
    } scan_regs_t;

    scan_regs_t          r_d, r_q;
    logic [NUM_ROWS-1:0] rows_sync;
    logic [NUM_ROWS-1:0] snap_rd;
    logic                snap_wr;
    logic                pend_any;
    logic [ROW_W-1:0]    pend_idx;
    logic [NUM_ROWS-1:0] pend_left;
    logic [NUM_ROWS-1:0] diff;

    // separate row pin sits above the contiguous ones, so it is reported last
    kbd_row_sync #(.WIDTH(NUM_ROWS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({row_extra_i, row_main_i}),
        .sync_o  (rows_sync)
    );

    kbd_snap_store #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .COL_W(COL_W)) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (snap_wr),
        .col_i     (r_q.col),
        .wr_data_i (r_q.sample),
        .rd_data_o (snap_rd)
    );

    kbd_lowbit_finder #(.WIDTH(NUM_ROWS), .IDX_W(ROW_W)) u_find (
        .vec_i (r_q.pending),
        .any_o (pend_any),
        .idx_o (pend_idx)
    );

    function automatic logic [COL_W-1:0] next_col(input logic [COL_W-1:0] c);
        return (c == COL_W'(NUM_COLS - 1)) ? '0 : c + 1'b1;
    endfunction

    always_comb begin
        r_d       = r_q;
        snap_wr   = 1'b0;
        diff      = rows_sync ^ snap_rd;
        pend_left = r_q.pending & ~(NUM_ROWS'(1) << pend_idx);
        case (r_q.st)
            SCAN_SETTLE: begin
                if (r_q.cnt >= settle_cycles) begin
                    r_d.sample = rows_sync;
                    if (diff == '0) begin
                        r_d.col = next_col(r_q.col);
                        r_d.cnt = '0;
                    end else begin
                        r_d.pending = diff;
                        r_d.st      = SCAN_EMIT;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            SCAN_EMIT: begin
                if (evt_ready_i) begin
                    r_d.pending = pend_left;
                    if (pend_left == '0) begin
                        snap_wr = 1'b1;
                        r_d.col = next_col(r_q.col);
                        r_d.cnt = '0;
                        r_d.st  = SCAN_SETTLE;
                    end
                end
            end
            default: r_d.st = SCAN_SETTLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= SCAN_SETTLE;
            r_q.col     <= '0;
            r_q.cnt     <= '0;
            r_q.sample  <= '1;
            r_q.pending <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign col_oe_o      = NUM_COLS'(1) << r_q.col;
    assign col_drv_o     = ~col_oe_o;
    assign evt_valid_o   = (r_q.st == SCAN_EMIT) && pend_any;
    assign evt_col_o     = r_q.col;
    assign evt_row_o     = pend_idx;
    assign evt_release_o = r_q.sample[pend_idx];
endmodule

// File: rtl/kbd_scan_checker.sv
module kbd_scan_checker #(
    parameter int NUM_COLS = 8,
    parameter int NUM_ROWS = 17,
    parameter int COL_W    = 3,
    parameter int ROW_W    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_COLS-1:0] col_oe_o,
    input logic [NUM_COLS-1:0] col_drv_o,
    input logic                evt_valid_o,
    input logic                evt_ready_i,
    input logic [COL_W-1:0]    evt_col_o,
    input logic [ROW_W-1:0]    evt_row_o,
    input logic                evt_release_o
);
    a_r2_one_column: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_oe_o) == 1);

    a_r2_driven_low: assert property (@(posedge clk) disable iff (!rst_n)
        (col_oe_o & col_drv_o) == '0);

    a_r3_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(col_oe_o) |->
            col_oe_o == {$past(col_oe_o[NUM_COLS-2:0]), $past(col_oe_o[NUM_COLS-1])});

    a_r6_event_column: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> col_oe_o[evt_col_o]);

    a_r7_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> evt_row_o < ROW_W'(NUM_ROWS));

    a_r8_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o && !evt_ready_i |=>
            evt_valid_o && $stable({evt_col_o, evt_row_o, evt_release_o}));

    a_r8_hold_column: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o && !evt_ready_i |=> $stable(col_oe_o));
endmodule

bind kbd_matrix_scanner kbd_scan_checker #(
    .NUM_COLS (NUM_COLS),
    .NUM_ROWS (NUM_ROWS),
    .COL_W    (COL_W),
    .ROW_W    (ROW_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .col_oe_o      (col_oe_o),
    .col_drv_o     (col_drv_o),
    .evt_valid_o   (evt_valid_o),
    .evt_ready_i   (evt_ready_i),
    .evt_col_o     (evt_col_o),
    .evt_row_o     (evt_row_o),
    .evt_release_o (evt_release_o)
);

// File: tb/sim_kbd_matrix_scanner.sv
module sim_kbd_matrix_scanner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  settle_cycles = 8'd3;
    logic [15:0] row_main_i;
    logic        row_extra_i;
    logic [7:0]  col_oe_o, col_drv_o;
    logic        evt_valid_o;
    logic        evt_ready_i = 1'b1;
    logic [2:0]  evt_col_o;
    logic [4:0]  evt_row_o;
    logic        evt_release_o;

    always #10 clk = ~clk;

    kbd_matrix_scanner u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .settle_cycles (settle_cycles),
        .row_main_i    (row_main_i),
        .row_extra_i   (row_extra_i),
        .col_oe_o      (col_oe_o),
        .col_drv_o     (col_drv_o),
        .evt_valid_o   (evt_valid_o),
        .evt_ready_i   (evt_ready_i),
        .evt_col_o     (evt_col_o),
        .evt_row_o     (evt_row_o),
        .evt_release_o (evt_release_o)
    );

    // key model: 1 = pressed; pressed key in a low-driven column pulls its row low
    logic [16:0] keys [8];
    logic [16:0] rows;
    always_comb begin
        rows = '1;
        for (int c = 0; c < 8; c++) begin
            if (col_oe_o[c] && !col_drv_o[c]) rows = rows & ~keys[c];
        end
    end
    assign row_main_i  = rows[15:0];
    assign row_extra_i = rows[16];

    // event monitor (own counters only)
    int hit [8][17];
    int rel [8][17];
    int ev_total = 0;
    int order_bad = 0;
    int step_id = 0;
    int mon_step = -1;
    int last_col = -1;
    int last_row = -1;
    always @(negedge clk) begin
        if (rst_n && evt_valid_o && evt_ready_i) begin
            if (mon_step != step_id) begin
                mon_step = step_id;
                last_col = -1;
            end
            if (int'(evt_col_o) == last_col && int'(evt_row_o) <= last_row) order_bad++;
            last_col = int'(evt_col_o);
            last_row = int'(evt_row_o);
            if (evt_row_o < 17) begin
                hit[evt_col_o][evt_row_o]++;
                rel[evt_col_o][evt_row_o] = int'(evt_release_o);
            end
            ev_total++;
        end
    end

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stimulus table: {column, toggle mask, expected event count}
    localparam logic [24:0] STIM [6] = '{
        {3'd0, 17'h00001, 5'd1},
        {3'd0, 17'h00001, 5'd1},
        {3'd3, 17'h10005, 5'd3},
        {3'd7, 17'h0FFFF, 5'd16},
        {3'd3, 17'h10000, 5'd1},
        {3'd5, 17'h18000, 5'd2}
    };

    int base_hit [8][17];
    int base_total;
    int base_order;

    task automatic snap_base();
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 17; r++) base_hit[c][r] = hit[c][r];
        base_total = ev_total;
        base_order = order_bad;
        step_id++;
    endtask

    task automatic verify_col(input int c, input logic [16:0] mask);
        for (int r = 0; r < 17; r++) begin
            if (mask[r]) begin
                check("R6 one event per changed key", hit[c][r] - base_hit[c][r], 1);
                check("R6 release flag equals new level", rel[c][r], keys[c][r] ? 0 : 1);
            end else begin
                check("R5 unchanged key silent", hit[c][r] - base_hit[c][r], 0);
            end
        end
    endtask

    task automatic wait_col_change(output logic [7:0] now);
        logic [7:0] prev;
        prev = col_oe_o;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (col_oe_o != prev) break;
        end
        now = col_oe_o;
    endtask

    task automatic measure_dwell(input int exp);
        logic [7:0] cur;
        int n;
        wait_col_change(cur);
        n = 1;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (col_oe_o == cur) n++;
            else break;
        end
        check("R4 dwell equals settle_cycles+1", n, exp);
    endtask

    initial begin
        for (int c = 0; c < 8; c++) keys[c] = '0;
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 17; r++) begin
                hit[c][r] = 0;
                rel[c][r] = 0;
            end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset enables column 0", int'(col_oe_o), 1);
        check("R1 reset drives column 0 low", int'(col_drv_o[0]), 0);
        check("R1 no event after reset", int'(evt_valid_o), 0);

        // R1/R5: idle matrix produces nothing
        repeat (400) @(negedge clk);
        check("R1 all released gives no events", ev_total, 0);

        // R2/R3: column sequence
        begin
            logic [7:0] cur;
            int idx0;
            wait_col_change(cur);
            idx0 = $clog2(int'(cur));
            for (int k = 1; k <= 16; k++) begin
                wait_col_change(cur);
                check("R2 one column enabled", $countones(cur), 1);
                check("R3 ascending wrapping order", int'(cur), 1 << ((idx0 + k) % 8));
                check("R2 active column low", int'(|(cur & col_drv_o)), 0);
            end
        end

        // R4: dwell for two settle values
        measure_dwell(4);
        @(posedge clk); #2 settle_cycles = 8'd6;
        wait_col_change(col_oe_o);
        measure_dwell(7);
        @(posedge clk); #2 settle_cycles = 8'd3;

        // table-driven key changes
        for (int s = 0; s < 6; s++) begin
            int c;
            logic [16:0] m;
            c = int'(STIM[s][24:22]);
            m = STIM[s][21:5];
            snap_base();
            @(posedge clk); #2 keys[c] = keys[c] ^ m;
            repeat (600) @(negedge clk);
            verify_col(c, m);
            check("R6 event count per step", ev_total - base_total, int'(STIM[s][4:0]));
            check("R7 ascending rows, row 16 last", order_bad - base_order, 0);
        end

        // two columns changing together
        snap_base();
        @(posedge clk); #2 keys[1] = keys[1] ^ 17'h1_8001; keys[6] = keys[6] ^ 17'h0_0110;
        repeat (600) @(negedge clk);
        verify_col(1, 17'h1_8001);
        verify_col(6, 17'h0_0110);
        check("R6 two-column event count", ev_total - base_total, 5);
        check("R7 order in each column", order_bad - base_order, 0);

        // R8/R9: stall
        snap_base();
        @(posedge clk); #2 evt_ready_i = 1'b0; keys[2] = keys[2] ^ 17'h00006;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (evt_valid_o) break;
        end
        check("R8 event raised while stalled", int'(evt_valid_o), 1);
        check("R6 stalled event column", int'(evt_col_o), 2);
        check("R7 first row is lowest", int'(evt_row_o), 1);
        check("R6 press gives release 0", int'(evt_release_o), 0);
        begin
            logic [7:0] oe0;
            logic [8:0] pay0;
            int bad;
            oe0 = col_oe_o;
            pay0 = {evt_col_o, evt_row_o, evt_release_o};
            bad = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (!evt_valid_o || col_oe_o != oe0 ||
                    {evt_col_o, evt_row_o, evt_release_o} != pay0) bad++;
            end
            check("R8 payload and column held during stall", bad, 0);
        end
        check("R8 nothing accepted during stall", ev_total - base_total, 0);
        @(posedge clk); #2 evt_ready_i = 1'b1;
        repeat (600) @(negedge clk);
        verify_col(2, 17'h00006);
        check("R9 exactly two events after stall", ev_total - base_total, 2);
        check("R7 order after stall", order_bad - base_order, 0);

        // R9: releasing all keys reported once each, then silence
        snap_base();
        @(posedge clk); #2 keys[2] = '0;
        repeat (600) @(negedge clk);
        check("R9 release after stall", ev_total - base_total, 2);
        check("R6 release flag row 1", rel[2][1], 1);
        base_total = ev_total;
        repeat (600) @(negedge clk);
        check("R9 no duplicate events", ev_total - base_total, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
            $finish;
        end
    end
endmodule